// File: doc/BRIEF.md
# Minterm Blit Combiner with Row/Column Modulo

This block is the per-byte arithmetic and sequencing core of a blitter-style transfer engine. A job is armed with a start pulse, which samples a command byte, the rectangle limits, the modulo step and the per-channel modulo selection. Each accepted byte strobe then combines the current source and destination bytes through a four-term Boolean function (any of the sixteen two-input functions, applied bitwise) and produces a registered result for the destination write.

While the job runs, a column counter and a row counter walk a rectangle. At the end of every row except the last, the block raises an address-adjust request for each channel whose modulo stepping is on, so the address units can add the captured modulo step. After the last byte of the last row, the job ends and a done flag is raised. The block does not perform memory accesses. The address units and the memory port around it do that.

Top module: `blit_combiner`

## Requirements
- R1: The four minterm enables come from command bits 4..7, sampled at start. Bit 4 selects ~S&~D, bit 5 selects ~S&D, bit 6 selects S&~D and bit 7 selects S&D. Each result bit is the OR of the selected terms for that bit position.
- R2: For each strobe that is accepted while the job is busy, `resByte` is updated and `resValid` is high on the following clock cycle. A strobe that arrives while the job is not busy, or in the same cycle as `start`, leaves `resByte` unchanged and does not raise `resValid`.
- R3: `start` clears both counters and loads new limits. On the next cycle `busy` is 1 and `done` is 0.
- R4: With a column limit value C, where 0 means 256, a row consists of C+1 accepted bytes.
- R5: With a row limit value R, where 0 means 256, the job consists of R+1 rows. In the cycle after the final byte, `busy` falls and `done` rises. `done` stays high until the next `start`.
- R6: When a row ends and it is not the final row, `srcAdjust` and/or `dstAdjust` pulse together with that byte's `resValid`, one pulse for each channel whose modulo is enabled. `modStep` holds the modulo value that was sampled at start.
- R7: If `useSubcmd`=1, the source modulo enable is `subCmd` bit 0 and the destination modulo enable is `subCmd` bit 2. Otherwise the enables are taken from `srcAddrMod` and `dstAddrMod`.
- R8: If `modSupport`=0 at start, both channel modulo enables are forced to 0 and no adjust request is issued during that job.
- R9: `jobLen` equals rowLimit*256 + colLimit, using the raw values sampled at start.
- R10: A `start` pulse during a busy job abandons that job and begins a new one using the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Arms a new job and samples its configuration |
| cmdByte | input | 8 | Command byte; bits 7..4 are the minterm enables |
| useSubcmd | input | 1 | Selects whether modulo enables come from the subcommand or from the address flags |
| subCmd | input | 8 | Subcommand byte; bit 0 enables source modulo, bit 2 enables destination modulo |
| srcAddrMod | input | 1 | Modulo flag carried in the source address |
| dstAddrMod | input | 1 | Modulo flag carried in the destination address |
| modSupport | input | 1 | Global permission for modulo stepping |
| colLimit | input | CNT_W | Column limit (0 = 256) |
| rowLimit | input | CNT_W | Row limit (0 = 256) |
| moduloVal | input | MOD_W | Modulo step added at each row end |
| byteStb | input | 1 | One pulse per transferred byte |
| srcByte | input | DATA_W | Source byte |
| dstByte | input | DATA_W | Destination byte |
| resByte | output | DATA_W | Registered combined result |
| resValid | output | 1 | Result was updated this cycle |
| srcAdjust | output | 1 | Request to add `modStep` to the source address |
| dstAdjust | output | 1 | Request to add `modStep` to the destination address |
| modStep | output | MOD_W | Modulo step captured at start |
| jobLen | output | 2*CNT_W | Transfer length code {rowLimit, colLimit} |
| busy | output | 1 | Job in progress |
| done | output | 1 | Job completed |

## Verification
The combiner is driven with several minterm sets: copy-source, exclusive-or, equivalence, inverted source, all-ones and all-zeros. Each set is fed random byte pairs, so a term swapped between two enable bits or an inverted operand produces a different result. The rectangle shapes are chosen to separate the column-count boundary from the row-count boundary, and they include a zero column limit and a zero row limit, which shows whether zero is treated as 256.

Modulo selection is checked four ways: subcommand bits with both channels on, subcommand bits with one channel on, the address-flag path with the subcommand set in conflict, and global support turned off. Each case fixes a different expected number of adjust pulses per channel. The remaining checks cover strobes gapped or idle, strobes after completion, and a restart in the middle of a job, which exercise the ignore and re-arm behaviour.

// File: rtl/blit_pkg.sv
package blit_pkg;

  // Per-cycle decisions made by the control path and consumed by the datapath
  typedef struct packed {
    logic capture;  // job is being armed this cycle
    logic take;     // a byte is accepted this cycle
    logic rowWrap;  // accepted byte closes a row that is not the last
    logic finish;   // accepted byte closes the whole rectangle
  } blitStb_t;

  // Field positions inside the command and subcommand bytes
  localparam int MT_LSB      = 4;
  localparam int SRC_SUB_BIT = 0;
  localparam int DST_SUB_BIT = 2;

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             byteStb,
  input  logic [CNT_W-1:0] colLimit,
  input  logic [CNT_W-1:0] rowLimit,
  output blitStb_t         stb,
  output logic             busy,
  output logic             done
);

  localparam int LIM_W = CNT_W + 1;
  localparam logic [LIM_W-1:0] LIM_FULL = {1'b1, {CNT_W{1'b0}}};

  logic [LIM_W-1:0] colLimQ, rowLimQ;
  logic [LIM_W-1:0] colCnt, rowCnt;
  logic [LIM_W-1:0] colLimNew, rowLimNew;
  logic             colHit, rowHit;

  // A zero limit stands for the full counter range
  always_comb begin
    colLimNew = (colLimit == '0) ? LIM_FULL : {1'b0, colLimit};
    rowLimNew = (rowLimit == '0) ? LIM_FULL : {1'b0, rowLimit};
  end

  assign colHit = (colCnt == colLimQ);
  assign rowHit = (rowCnt == rowLimQ);

  always_comb begin
    stb.capture = start;
    stb.take    = byteStb && busy && !start;
    stb.rowWrap = stb.take && colHit && !rowHit;
    stb.finish  = stb.take && colHit && rowHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colLimQ <= '0;
      rowLimQ <= '0;
      colCnt  <= '0;
      rowCnt  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (stb.capture) begin
      colLimQ <= colLimNew;
      rowLimQ <= rowLimNew;
      colCnt  <= '0;
      rowCnt  <= '0;
      busy    <= 1'b1;
      done    <= 1'b0;
    end else if (stb.take) begin
      if (colHit) begin
        colCnt <= '0;
        if (rowHit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rowCnt <= rowCnt + 1'b1;
        end
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int MOD_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  blitStb_t           stb,
  input  logic [7:0]         cmdByte,
  input  logic               useSubcmd,
  input  logic [7:0]         subCmd,
  input  logic               srcAddrMod,
  input  logic               dstAddrMod,
  input  logic               modSupport,
  input  logic [CNT_W-1:0]   colLimit,
  input  logic [CNT_W-1:0]   rowLimit,
  input  logic [MOD_W-1:0]   moduloVal,
  input  logic [DATA_W-1:0]  srcByte,
  input  logic [DATA_W-1:0]  dstByte,
  output logic [DATA_W-1:0]  resByte,
  output logic               resValid,
  output logic               srcAdjust,
  output logic               dstAdjust,
  output logic [MOD_W-1:0]   modStep,
  output logic [2*CNT_W-1:0] jobLen
);

  localparam int N_CHAN = 2;

  logic [3:0]        mtQ;
  logic [N_CHAN-1:0] modEnQ, modPick, addrMod, adjQ;
  logic [DATA_W-1:0] mixed;

  assign addrMod = {dstAddrMod, srcAddrMod};

  // Modulo enable selection per channel
  generate
    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
      localparam int SUB_BIT = (ch == 0) ? SRC_SUB_BIT : DST_SUB_BIT;
      assign modPick[ch] = modSupport && (useSubcmd ? subCmd[SUB_BIT] : addrMod[ch]);
    end
  endgenerate

  // Bitwise four-term function of source and destination
  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign mixed[b] = ( srcByte[b] &  dstByte[b] & mtQ[3]) |
                        ( srcByte[b] & ~dstByte[b] & mtQ[2]) |
                        (~srcByte[b] &  dstByte[b] & mtQ[1]) |
                        (~srcByte[b] & ~dstByte[b] & mtQ[0]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mtQ      <= '0;
      modEnQ   <= '0;
      modStep  <= '0;
      jobLen   <= '0;
      resByte  <= '0;
      resValid <= 1'b0;
      adjQ     <= '0;
    end else begin
      resValid <= stb.take;
      adjQ     <= {N_CHAN{stb.rowWrap}} & modEnQ;
      if (stb.capture) begin
        mtQ     <= cmdByte[MT_LSB +: 4];
        modEnQ  <= modPick;
        modStep <= moduloVal;
        jobLen  <= {rowLimit, colLimit};
      end
      if (stb.take) begin
        resByte <= mixed;
      end
    end
  end

  assign srcAdjust = adjQ[0];
  assign dstAdjust = adjQ[1];

endmodule

// File: rtl/blit_combiner.sv
module blit_combiner
  import blit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int MOD_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [7:0]         cmdByte,
  input  logic               useSubcmd,
  input  logic [7:0]         subCmd,
  input  logic               srcAddrMod,
  input  logic               dstAddrMod,
  input  logic               modSupport,
  input  logic [CNT_W-1:0]   colLimit,
  input  logic [CNT_W-1:0]   rowLimit,
  input  logic [MOD_W-1:0]   moduloVal,
  input  logic               byteStb,
  input  logic [DATA_W-1:0]  srcByte,
  input  logic [DATA_W-1:0]  dstByte,
  output logic [DATA_W-1:0]  resByte,
  output logic               resValid,
  output logic               srcAdjust,
  output logic               dstAdjust,
  output logic [MOD_W-1:0]   modStep,
  output logic [2*CNT_W-1:0] jobLen,
  output logic               busy,
  output logic               done
);

  blitStb_t stb;

  blit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .byteStb  (byteStb),
    .colLimit (colLimit),
    .rowLimit (rowLimit),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  blit_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cmdByte    (cmdByte),
    .useSubcmd  (useSubcmd),
    .subCmd     (subCmd),
    .srcAddrMod (srcAddrMod),
    .dstAddrMod (dstAddrMod),
    .modSupport (modSupport),
    .colLimit   (colLimit),
    .rowLimit   (rowLimit),
    .moduloVal  (moduloVal),
    .srcByte    (srcByte),
    .dstByte    (dstByte),
    .resByte    (resByte),
    .resValid   (resValid),
    .srcAdjust  (srcAdjust),
    .dstAdjust  (dstAdjust),
    .modStep    (modStep),
    .jobLen     (jobLen)
  );

endmodule

// File: rtl/blit_combiner_chk.sv
module blit_combiner_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int MOD_W  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               modSupport,
  input logic [CNT_W-1:0]   colLimit,
  input logic [CNT_W-1:0]   rowLimit,
  input logic               byteStb,
  input logic               resValid,
  input logic               srcAdjust,
  input logic               dstAdjust,
  input logic [2*CNT_W-1:0] jobLen,
  input logic               busy,
  input logic               done
);

  // Observed permission for the current job, tracked from the ports
  logic supSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      supSeen <= 1'b0;
    else if (start) supSeen <= modSupport;
  end

  p_valid_after_stb_r2: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(byteStb && busy && !start));

  p_start_arms_r3: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && !done && !resValid));

  p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  p_adjust_with_result_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcAdjust || dstAdjust) |-> resValid);

  p_adjust_permitted_r8: assert property (@(posedge clk) disable iff (!rstN)
    (srcAdjust || dstAdjust) |-> supSeen);

  p_job_len_r9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (jobLen == $past({rowLimit, colLimit})));

endmodule

bind blit_combiner blit_combiner_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MOD_W(MOD_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .modSupport (modSupport),
  .colLimit   (colLimit),
  .rowLimit   (rowLimit),
  .byteStb    (byteStb),
  .resValid   (resValid),
  .srcAdjust  (srcAdjust),
  .dstAdjust  (dstAdjust),
  .jobLen     (jobLen),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_blit_combiner.sv
module test_blit_combiner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic        useSubcmd = 1'b0;
  logic [7:0]  subCmd = '0;
  logic        srcAddrMod = 1'b0;
  logic        dstAddrMod = 1'b0;
  logic        modSupport = 1'b0;
  logic [7:0]  colLimit = '0;
  logic [7:0]  rowLimit = '0;
  logic [15:0] moduloVal = '0;
  logic        byteStb = 1'b0;
  logic [7:0]  srcByte = '0;
  logic [7:0]  dstByte = '0;
  logic [7:0]  resByte;
  logic        resValid, srcAdjust, dstAdjust, busy, done;
  logic [15:0] modStep;
  logic [15:0] jobLen;

  always #4 clk = ~clk;  // 125 MHz

  blit_combiner i_blit_combiner (
    .clk(clk), .rstN(rstN), .start(start), .cmdByte(cmdByte), .useSubcmd(useSubcmd),
    .subCmd(subCmd), .srcAddrMod(srcAddrMod), .dstAddrMod(dstAddrMod),
    .modSupport(modSupport), .colLimit(colLimit), .rowLimit(rowLimit),
    .moduloVal(moduloVal), .byteStb(byteStb), .srcByte(srcByte), .dstByte(dstByte),
    .resByte(resByte), .resValid(resValid), .srcAdjust(srcAdjust), .dstAdjust(dstAdjust),
    .modStep(modStep), .jobLen(jobLen), .busy(busy), .done(done)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int   mRes = 0, mValid = 0, mSrcAdj = 0, mDstAdj = 0, mBusy = 0, mDone = 0;
  int   mJob = 0, mStep = 0, mCol = 0, mRow = 0, mColL = 0, mRowL = 0;
  int   mMask = 0, mSEn = 0, mDEn = 0;
  bit   startSeen = 0;

  function automatic int mix(int s, int d, int m);
    int r = 0;
    for (int b = 0; b < 8; b++) begin
      int sel = ((s >> b) & 1) * 2 + ((d >> b) & 1);
      r |= ((m >> sel) & 1) << b;  // sel 3:S&D 2:S&~D 1:~S&D 0:~S&~D
    end
    return r;
  endfunction

  always @(posedge clk) begin
    startSeen <= start;
    if (rstN) begin
      mValid  <= 0;
      mSrcAdj <= 0;
      mDstAdj <= 0;
      if (start) begin
        mBusy <= 1; mDone <= 0; mCol <= 0; mRow <= 0;
        mColL <= (colLimit == 0) ? 256 : int'(colLimit);
        mRowL <= (rowLimit == 0) ? 256 : int'(rowLimit);
        mMask <= int'(cmdByte) / 16;
        mSEn  <= int'(modSupport && (useSubcmd ? subCmd[0] : srcAddrMod));
        mDEn  <= int'(modSupport && (useSubcmd ? subCmd[2] : dstAddrMod));
        mJob  <= int'(rowLimit) * 256 + int'(colLimit);
        mStep <= int'(moduloVal);
      end else if (byteStb && mBusy == 1) begin
        mValid <= 1;
        mRes   <= mix(int'(srcByte), int'(dstByte), mMask);
        if (mCol == mColL) begin
          if (mRow == mRowL) begin
            mBusy <= 0; mDone <= 1;
          end else begin
            mCol <= 0; mRow <= mRow + 1;
            mSrcAdj <= mSEn; mDstAdj <= mDEn;
          end
        end else begin
          mCol <= mCol + 1;
        end
      end
    end
  end

  int nValid = 0, nSrcAdj = 0, nDstAdj = 0;

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (startSeen) begin nValid = 0; nSrcAdj = 0; nDstAdj = 0; end
      nValid  += int'(resValid);
      nSrcAdj += int'(srcAdjust);
      nDstAdj += int'(dstAdjust);
      chk(int'(resByte) == mRes, "R1 resByte", resByte, mRes);
      chk(int'(resValid) == mValid, "R2 resValid", resValid, mValid);
      chk(int'(busy) == mBusy, "R5 busy", busy, mBusy);
      chk(int'(done) == mDone, "R5 done", done, mDone);
      chk(int'(srcAdjust) == mSrcAdj, "R6 srcAdjust", srcAdjust, mSrcAdj);
      chk(int'(dstAdjust) == mDstAdj, "R6 dstAdjust", dstAdjust, mDstAdj);
      chk(int'(modStep) == mStep, "R6 modStep", modStep, mStep);
      chk(int'(jobLen) == mJob, "R9 jobLen", jobLen, mJob);
    end
  end

  task automatic armJob(input logic [7:0] cmd, input logic uSub, input logic [7:0] sub,
                        input logic sA, input logic dA, input logic sup,
                        input logic [7:0] c, input logic [7:0] r, input logic [15:0] mv);
    @(negedge clk);
    cmdByte = cmd; useSubcmd = uSub; subCmd = sub; srcAddrMod = sA; dstAddrMod = dA;
    modSupport = sup; colLimit = c; rowLimit = r; moduloVal = mv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R3 armed", {busy, done}, 2'b10);
  endtask

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      byteStb = 1'b1; srcByte = 8'($urandom); dstByte = 8'($urandom);
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        byteStb = 1'b0;
        @(negedge clk);
      end
    end
    byteStb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runJob(input logic [7:0] cmd, input logic uSub, input logic [7:0] sub,
                        input logic sA, input logic dA, input logic sup,
                        input logic [7:0] c, input logic [7:0] r, input bit gaps,
                        input int expSrc, input int expDst);
    int cE = (c == 0) ? 256 : int'(c);
    int rE = (r == 0) ? 256 : int'(r);
    armJob(cmd, uSub, sub, sA, dA, sup, c, r, 16'h0140 + 16'(c));
    feed((cE + 1) * (rE + 1), gaps);
    chk(nValid == (cE + 1) * (rE + 1), "R4 byte count", nValid, (cE + 1) * (rE + 1));
    chk(done == 1'b1 && busy == 1'b0, "R5 job end", {busy, done}, 2'b01);
    chk(nSrcAdj == expSrc, "R6 R7 R8 src adjusts", nSrcAdj, expSrc);
    chk(nDstAdj == expDst, "R6 R7 R8 dst adjusts", nDstAdj, expDst);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && resValid == 0, "R5 reset state", {busy, done, resValid}, 0);
    chk(srcAdjust == 0 && dstAdjust == 0 && jobLen == 0, "R9 reset state",
        {srcAdjust, dstAdjust}, 0);
    rstN = 1'b1;
    // copy source, both channels via subcommand
    runJob(8'hC0, 1, 8'h05, 0, 0, 1, 8'd2, 8'd1, 0, 1, 1);
    // idle strobes after completion are ignored
    feed(3, 0);
    chk(nValid == 6, "R2 idle strobes ignored", nValid, 6);
    // exclusive-or, destination only, gapped strobes
    runJob(8'h60, 1, 8'h04, 1, 1, 1, 8'd3, 8'd2, 1, 0, 2);
    // equivalence, address flags win over subcommand bits
    runJob(8'h90, 0, 8'h05, 1, 0, 1, 8'd1, 8'd3, 0, 3, 0);
    // inverted source, modulo support off
    runJob(8'h30, 1, 8'h05, 1, 1, 0, 8'd2, 8'd2, 0, 0, 0);
    // all ones, zero column limit
    runJob(8'hF0, 1, 8'h05, 0, 0, 1, 8'd0, 8'd1, 0, 1, 1);
    // all zeros, zero row limit
    runJob(8'h00, 1, 8'h05, 0, 0, 1, 8'd1, 8'd0, 0, 256, 256);
    // restart in the middle of a job
    armJob(8'hA0, 1, 8'h01, 0, 0, 1, 8'd4, 8'd4, 16'h0011);
    feed(5, 0);
    chk(busy == 1'b1, "R10 still busy", busy, 1);
    armJob(8'hA0, 1, 8'h01, 0, 0, 1, 8'd1, 8'd1, 16'h0022);
    feed(4, 0);
    chk(nValid == 4, "R10 restart count", nValid, 4);
    chk(done == 1'b1, "R10 restart done", done, 1);
    chk(nSrcAdj == 1 && nDstAdj == 0, "R10 restart adjusts", {nSrcAdj, nDstAdj}, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule